// File: doc/BRIEF.md
# Stepwise Division Control Unit

This block provides the hardware half of a software division loop. It keeps three status bits between instructions: M, the divisor sign; Q, the sign of the partial remainder; and T, the latest quotient bit. It carries out three primitives.

- An unsigned setup clears all three bits.
- A signed setup loads Q and M from the sign bits of the two operands.
- A one-bit step produces the next partial remainder and the next quotient bit.

Software issues a setup, then one step for each quotient bit. It feeds the returned register value back in as the next dividend operand, and at the end it folds the final T into the result.

Each primitive takes one clock. The status bits and the step result are registered, so their new values are visible in the cycle after the clock edge that accepts the operation. A new operation may be accepted on every cycle. A step reports its written value together with the register index taken from the opcode.

Top module: `stepdiv_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, M, Q, T and the result strobe `res_valid` are all 0.
- R2: The unsigned setup (opcode exactly 0x0019) clears M, Q and T to 0 on the next cycle and writes no register.
- R3: The signed setup has opcode bits [15:12]=0x2 and [3:0]=0x7. On the next cycle Q equals bit 31 of `rn_val`, M equals bit 31 of `rm_val`, T equals M XOR Q, and no register is written.
- R4: The one-bit step has opcode bits [15:12]=0x3 and [3:0]=0x4. It first shifts `rn_val` left by one, with the old T entering bit 0. It then subtracts `rm_val` when the old Q equals M, and adds it otherwise. On the next cycle the 32-bit result is on `res_data`, `res_valid` is 1 and `res_idx` equals opcode bits [11:8].
- R5: After a step, the new Q equals the old bit 31 of `rn_val` XOR M XOR the carry-out. The carry-out is the carry of the add or the borrow of the subtract. The new T is 1 exactly when the new Q equals M, and M is unchanged.
- R6: An opcode that matches none of the three primitives, or any cycle with `op_valid` low, leaves M, Q and T unchanged and gives `res_valid` 0 on the next cycle.
- R7: Operations issued on consecutive cycles are each applied in one cycle, and each sees the flags left by the one before it.
- R8: An unsigned setup, then 16 steps with divisor<<16 and a zero-extended 16-bit dividend, then the fold ((result<<1)|T) with the low 16 bits kept, gives the unsigned quotient.
- R9: The signed sequence gives the truncated signed quotient for any pair whose quotient fits in 16 signed bits. The sequence is: subtract the dividend sign from the sign-extended dividend, apply the signed setup with divisor<<16, take 16 steps, sign-extend the low half, rotate T in through bit 0 while keeping the shifted-out sign bit, add that sign bit, and sign-extend the low half again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 16 | Instruction opcode |
| rn_val | input | 32 | Dividend / partial remainder operand |
| rm_val | input | 32 | Divisor operand |
| res_valid | output | 1 | A step result is present this cycle |
| res_idx | output | 4 | Destination register index of the step |
| res_data | output | 32 | Updated partial remainder |
| m_flag | output | 1 | Divisor sign bit M |
| q_flag | output | 1 | Remainder sign bit Q |
| t_flag | output | 1 | Quotient bit T |

## Verification
The assertions take `op_valid`, `op_code` and both operands to be known (not X) at every clock edge outside reset. They also take it that the step operands are whatever software chose, with no precondition on their range. The bench therefore drives every input to a defined value on each falling edge, including the idle cycles.

The end-to-end sequences need a divisor whose high half exceeds the dividend's high half, so the quotient fits in 16 bits. The bench picks only such operand pairs. The single-step checks use arbitrary operands.

// File: rtl/stepdiv_pkg.sv
package stepdiv_pkg;

    localparam int OPC_W = 16;
    localparam int IDX_W = 4;

    // Fixed encodings of the three primitives
    localparam logic [OPC_W-1:0] CODE_SETUP_U = 16'h0019;
    localparam logic [3:0]       SETUP_S_HI   = 4'h2;
    localparam logic [3:0]       SETUP_S_LO   = 4'h7;
    localparam logic [3:0]       STEP_HI      = 4'h3;
    localparam logic [3:0]       STEP_LO      = 4'h4;

    typedef enum logic [1:0] {
        OPK_NONE    = 2'd0,
        OPK_SETUP_U = 2'd1,
        OPK_SETUP_S = 2'd2,
        OPK_STEP    = 2'd3
    } opk_e;

    typedef struct packed {
        logic m;
        logic q;
        logic t;
    } flags_t;

    typedef struct packed {
        opk_e             kind;
        logic [IDX_W-1:0] dst;
    } dec_t;

    function automatic dec_t classify(input logic [OPC_W-1:0] code);
        dec_t d;
        d.dst  = code[11:8];
        d.kind = OPK_NONE;
        if (code == CODE_SETUP_U)
            d.kind = OPK_SETUP_U;
        else if (code[15:12] == SETUP_S_HI && code[3:0] == SETUP_S_LO)
            d.kind = OPK_SETUP_S;
        else if (code[15:12] == STEP_HI && code[3:0] == STEP_LO)
            d.kind = OPK_STEP;
        return d;
    endfunction

    // A quotient bit is 1 when the remainder sign matches the divisor sign
    function automatic logic quot_bit(input logic q, input logic m);
        return q ~^ m;
    endfunction

endpackage

// File: rtl/stepdiv_decode.sv
module stepdiv_decode
    import stepdiv_pkg::*;
(
    input  logic             op_valid,
    input  logic [OPC_W-1:0] op_code,
    output opk_e             kind,
    output logic [IDX_W-1:0] dst
);
    dec_t raw;

    always_comb begin
        raw  = classify(op_code);
        kind = op_valid ? raw.kind : OPK_NONE;
        dst  = raw.dst;
    end
endmodule

// File: rtl/stepdiv_alu.sv
module stepdiv_alu
    import stepdiv_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  opk_e              kind,
    input  flags_t            cur,
    input  logic [DATA_W-1:0] rn_val,
    input  logic [DATA_W-1:0] rm_val,
    output flags_t            nxt,
    output logic [DATA_W-1:0] step_data
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] shifted;
    logic              lost_msb;
    logic              do_sub;
    logic [DATA_W:0]   wide;
    logic              cout;
    logic              q_step;

    always_comb begin
        shifted  = {rn_val[MSB-1:0], cur.t};
        lost_msb = rn_val[MSB];
        do_sub   = (cur.q == cur.m);
        if (do_sub)
            wide = {1'b0, shifted} - {1'b0, rm_val};
        else
            wide = {1'b0, shifted} + {1'b0, rm_val};
        cout      = wide[DATA_W];
        step_data = wide[DATA_W-1:0];
        q_step    = lost_msb ^ cur.m ^ cout;

        nxt = cur;
        unique case (kind)
            OPK_SETUP_U: nxt = '{m: 1'b0, q: 1'b0, t: 1'b0};
            OPK_SETUP_S: begin
                nxt.q = rn_val[MSB];
                nxt.m = rm_val[MSB];
                nxt.t = rn_val[MSB] ^ rm_val[MSB];
            end
            OPK_STEP: begin
                nxt.q = q_step;
                nxt.t = quot_bit(q_step, cur.m);
            end
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/stepdiv_state.sv
module stepdiv_state
    import stepdiv_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  opk_e              kind,
    input  logic [IDX_W-1:0]  dst,
    input  flags_t            nxt,
    input  logic [DATA_W-1:0] step_data,
    output flags_t            cur,
    output logic              res_valid,
    output logic [IDX_W-1:0]  res_idx,
    output logic [DATA_W-1:0] res_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= '0;
            res_valid <= 1'b0;
            res_idx   <= '0;
            res_data  <= '0;
        end else begin
            cur       <= nxt;
            res_valid <= (kind == OPK_STEP);
            if (kind == OPK_STEP) begin
                res_idx  <= dst;
                res_data <= step_data;
            end
        end
    end
endmodule

// File: rtl/stepdiv_unit.sv
module stepdiv_unit
    import stepdiv_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [15:0]       op_code,
    input  logic [DATA_W-1:0] rn_val,
    input  logic [DATA_W-1:0] rm_val,
    output logic              res_valid,
    output logic [3:0]        res_idx,
    output logic [DATA_W-1:0] res_data,
    output logic              m_flag,
    output logic              q_flag,
    output logic              t_flag
);
    opk_e              kind;
    logic [IDX_W-1:0]  dst;
    flags_t            cur;
    flags_t            nxt;
    logic [DATA_W-1:0] step_data;

    stepdiv_decode u_dec (
        .op_valid (op_valid),
        .op_code  (op_code),
        .kind     (kind),
        .dst      (dst)
    );

    stepdiv_alu #(.DATA_W(DATA_W)) u_alu (
        .kind      (kind),
        .cur       (cur),
        .rn_val    (rn_val),
        .rm_val    (rm_val),
        .nxt       (nxt),
        .step_data (step_data)
    );

    stepdiv_state #(.DATA_W(DATA_W)) u_st (
        .clk       (clk),
        .rst       (rst),
        .kind      (kind),
        .dst       (dst),
        .nxt       (nxt),
        .step_data (step_data),
        .cur       (cur),
        .res_valid (res_valid),
        .res_idx   (res_idx),
        .res_data  (res_data)
    );

    assign m_flag = cur.m;
    assign q_flag = cur.q;
    assign t_flag = cur.t;
endmodule

// File: rtl/stepdiv_checker.sv
module stepdiv_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [15:0]       op_code,
    input logic [DATA_W-1:0] rn_val,
    input logic [DATA_W-1:0] rm_val,
    input logic              res_valid,
    input logic [3:0]        res_idx,
    input logic [DATA_W-1:0] res_data,
    input logic              m_flag,
    input logic              q_flag,
    input logic              t_flag
);
    logic is_u, is_s, is_step, is_any;
    logic [DATA_W-1:0] sh_val;
    logic [DATA_W:0]   add_w, sub_w;

    always_comb begin
        is_u    = op_valid && op_code == 16'h0019;
        is_s    = op_valid && op_code[15:12] == 4'h2 && op_code[3:0] == 4'h7;
        is_step = op_valid && op_code[15:12] == 4'h3 && op_code[3:0] == 4'h4;
        is_any  = is_u || is_s || is_step;
        sh_val  = {rn_val[DATA_W-2:0], t_flag};
        add_w   = {1'b0, sh_val} + {1'b0, rm_val};
        sub_w   = {1'b0, sh_val} - {1'b0, rm_val};
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!m_flag && !q_flag && !t_flag && !res_valid));

    a_r2_unsigned_setup: assert property (@(posedge clk) disable iff (rst)
        is_u |=> (!m_flag && !q_flag && !t_flag && !res_valid));

    a_r3_signed_setup: assert property (@(posedge clk) disable iff (rst)
        is_s |=> (q_flag == $past(rn_val[DATA_W-1]) && m_flag == $past(rm_val[DATA_W-1])
                  && t_flag == (m_flag ^ q_flag) && !res_valid));

    a_r4_step_data: assert property (@(posedge clk) disable iff (rst)
        is_step |=> (res_valid && res_idx == $past(op_code[11:8])
                     && res_data == ($past(q_flag == m_flag) ? $past(sub_w[DATA_W-1:0])
                                                             : $past(add_w[DATA_W-1:0]))));

    a_r5_step_flags: assert property (@(posedge clk) disable iff (rst)
        is_step |=> ($stable(m_flag) && t_flag == (q_flag == m_flag)
                     && q_flag == ($past(rn_val[DATA_W-1]) ^ $past(m_flag)
                                   ^ ($past(q_flag == m_flag) ? $past(sub_w[DATA_W])
                                                              : $past(add_w[DATA_W])))));

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !is_any |=> ($stable(m_flag) && $stable(q_flag) && $stable(t_flag) && !res_valid));
endmodule

bind stepdiv_unit stepdiv_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .rn_val    (rn_val),
    .rm_val    (rm_val),
    .res_valid (res_valid),
    .res_idx   (res_idx),
    .res_data  (res_data),
    .m_flag    (m_flag),
    .q_flag    (q_flag),
    .t_flag    (t_flag)
);

// File: tb/stepdiv_unit_tb_top.sv
module stepdiv_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [15:0] op_code = 16'h0009;
    logic [31:0] rn_val = '0;
    logic [31:0] rm_val = '0;
    logic        res_valid;
    logic [3:0]  res_idx;
    logic [31:0] res_data;
    logic        m_flag, q_flag, t_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // bench-side flag model
    logic em, eq, et;

    stepdiv_unit dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .rn_val(rn_val), .rm_val(rm_val), .res_valid(res_valid),
        .res_idx(res_idx), .res_data(res_data),
        .m_flag(m_flag), .q_flag(q_flag), .t_flag(t_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] op_step(input int n, input int m);
        return 16'h3004 | 16'(n << 8) | 16'(m << 4);
    endfunction

    function automatic logic [15:0] op_sset(input int n, input int m);
        return 16'h2007 | 16'(n << 8) | 16'(m << 4);
    endfunction

    // Issue one operation at a falling edge; returns at the next falling edge
    task automatic issue(input logic [15:0] code, input logic [31:0] a, input logic [31:0] b);
        op_valid = 1'b1;
        op_code  = code;
        rn_val   = a;
        rm_val   = b;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // Independent model of one step, from R4 and R5
    task automatic model_step(input logic [31:0] a, input logic [31:0] b,
                              output logic [31:0] val);
        logic [32:0] w;
        logic [31:0] sh;
        logic        c, nq;
        sh = {a[30:0], et};
        if (eq == em) begin
            w = {1'b0, sh} - {1'b0, b};
        end else begin
            w = {1'b0, sh} + {1'b0, b};
        end
        c   = w[32];
        val = w[31:0];
        nq  = a[31] ^ em ^ c;
        eq  = nq;
        et  = (nq == em);
    endtask

    task automatic check_flags(input string req);
        check(req, "M", {31'b0, m_flag}, {31'b0, em});
        check(req, "Q", {31'b0, q_flag}, {31'b0, eq});
        check(req, "T", {31'b0, t_flag}, {31'b0, et});
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        em = 0; eq = 0; et = 0;
        check_flags("R1");
        check("R1", "res_valid", {31'b0, res_valid}, 32'd0);
    endtask

    task automatic t_signed_setup(input logic [31:0] a, input logic [31:0] b);
        issue(op_sset(2, 3), a, b);
        eq = a[31]; em = b[31]; et = a[31] ^ b[31];
        check_flags("R3");
        check("R3", "no write", {31'b0, res_valid}, 32'd0);
    endtask

    task automatic t_unsigned_setup();
        issue(16'h0019, 32'hFFFF_FFFF, 32'h8000_0000);
        em = 0; eq = 0; et = 0;
        check_flags("R2");
        check("R2", "no write", {31'b0, res_valid}, 32'd0);
    endtask

    task automatic t_single_step(input int n, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] exp;
        model_step(a, b, exp);
        issue(op_step(n, 1), a, b);
        check("R4", "data", res_data, exp);
        check("R4", "idx", {28'b0, res_idx}, n[31:0]);
        check("R4", "valid", {31'b0, res_valid}, 32'd1);
        check_flags("R5");
    endtask

    task automatic t_ignored();
        // unknown opcodes, and a valid-looking step with op_valid low
        issue(16'h0009, 32'h1234_5678, 32'h8765_4321);
        check_flags("R6");
        check("R6", "valid after unknown", {31'b0, res_valid}, 32'd0);
        issue(16'h3005, 32'hFFFF_FFFF, 32'h1);
        check_flags("R6");
        check("R6", "valid after near-miss", {31'b0, res_valid}, 32'd0);
        op_valid = 1'b0; op_code = op_step(5, 1); rn_val = 32'hAAAA_5555; rm_val = 32'h1;
        @(negedge clk);
        check_flags("R6");
        check("R6", "valid with strobe low", {31'b0, res_valid}, 32'd0);
    endtask

    task automatic t_unsigned_div(input logic [15:0] dd, input logic [15:0] dv);
        logic [31:0] r, q;
        t_unsigned_setup();
        r = {16'b0, dd};
        for (int i = 0; i < 16; i++) begin
            logic [31:0] exp;
            model_step(r, {dv, 16'b0}, exp);
            issue(op_step(1, 0), r, {dv, 16'b0});
            if (res_data !== exp) check("R7", "chained step", res_data, exp);
            r = res_data;
        end
        q = {16'b0, r[14:0], t_flag};
        check("R8", "unsigned quotient", q, {16'b0, dd / dv});
    endtask

    task automatic t_signed_div(input int dd, input int dv);
        logic [31:0] r, dvs;
        logic        sb;
        int          quo;
        r   = dd;
        dvs = dv << 16;
        r   = r - {31'b0, r[31]};
        t_signed_setup(r, dvs);
        for (int i = 0; i < 16; i++) begin
            issue(op_step(1, 0), r, dvs);
            r = res_data;
        end
        r   = {{16{r[15]}}, r[15:0]};
        sb  = r[31];
        r   = {r[30:0], t_flag};
        r   = r + {31'b0, sb};
        r   = {{16{r[15]}}, r[15:0]};
        quo = dd / dv;
        check("R9", "signed quotient", r, quo);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_signed_setup(32'h8000_0000, 32'h0000_0001);
        t_signed_setup(32'h7FFF_FFFF, 32'hF000_0000);
        t_signed_setup(32'hC000_0000, 32'h8000_0000);
        t_unsigned_setup();
        // steps covering both add and subtract, carry and borrow (R4, R5)
        t_single_step(3, 32'h0000_0010, 32'h0000_0020);
        t_single_step(7, 32'h8000_0001, 32'h0000_0004);
        t_single_step(15, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        t_signed_setup(32'h0000_0001, 32'h8000_0000);
        t_single_step(0, 32'h4000_0000, 32'h8000_0000);
        t_single_step(9, 32'hC000_0000, 32'h7000_0000);
        t_ignored();
        // full sequences, steps issued back to back (R7)
        t_unsigned_div(16'd100, 16'd7);
        t_unsigned_div(16'd65535, 16'd1);
        t_unsigned_div(16'd5, 16'd9);
        t_unsigned_div(16'd40000, 16'd40000);
        t_signed_div(-7, 2);
        t_signed_div(-8, 2);
        t_signed_div(100, -7);
        t_signed_div(-1000, -33);
        t_signed_div(32767, 3);
        t_signed_div(0, 5);
        // reset mid-state clears flags again
        t_signed_setup(32'h8000_0000, 32'h8000_0000);
        t_reset();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule